// File: doc/BRIEF.md
# Start-Stop Serial Receiver with Error and Break Detection

This block receives start-stop serial frames on a single line that idles high. A free-running sixteen-times oversampling enable (`tick16`) paces it. The receiver finds the falling edge of a start bit and confirms it at mid-cell. It then takes every later bit at the middle of its cell, least significant bit first.

Frames carry seven or eight data bits. An optional parity bit (even or odd) may follow, then an optional multiprocessor flag bit, then one or two stop bits. Each finished byte moves from the shift register into a holding register, so the next frame can shift in while the host has not yet read the last one. Parity, framing and overrun faults set three separate sticky flags. A byte-ready request and an error request go to the host.

The synchronised line level is brought out as a port. After a framing fault, the host can read it to tell a held-low break from a corrupted frame. The host acknowledges a read with a one-cycle strobe and clears all error flags with another.

Top module: `sci_async_rx`

## Requirements
- R1: While idle, a low line seen on a `tick16` pulse, after the line has been seen high, starts a frame. The line is sampled again on the 8th `tick16` pulse after that detection pulse. If it is high, the receiver returns to idle and stores nothing. If it is low, the start bit is accepted.
- R2: After an accepted start, one bit is sampled every 16 `tick16` pulses. Data bits are assembled least significant bit first. There are seven data bits when `cfg_len7`=1 and eight when it is 0. In seven-bit frames `rx_data[7]` reads 0.
- R3: When `cfg_par_en`=1, a parity bit follows the data. `err_parity` is set when the count of ones over the data and parity bits is odd with `cfg_par_odd`=0, or even with `cfg_par_odd`=1. When `cfg_par_en`=0, no parity bit is expected and `err_parity` is never set.
- R4: When `cfg_mp_en`=1, one multiprocessor bit follows the data and any parity bit. It is stored in `rx_mpb` together with the byte. When `cfg_mp_en`=0, `rx_mpb` is loaded with 0.
- R5: A stop bit sampled low sets `err_frame`. Only the first stop bit is examined, so two-stop frames are accepted. After a low stop bit, no new frame starts until the line has been high.
- R6: A frame that completes while `rx_full`=0 loads `rx_data` and `rx_mpb`, sets `rx_full`, and may set `err_parity` or `err_frame`. A frame that completes while `rx_full`=1 sets only `err_overrun`. The held byte and `rx_mpb` are kept, and everything else from the new frame is discarded.
- R7: A one-cycle `clr_full` pulse clears `rx_full`. A one-cycle `clr_err` pulse clears all three error flags. A frame completing in the same cycle takes priority over the clear.
- R8: `irq_rx_full` equals `rx_full`. `irq_rx_err` is high exactly when at least one of the three error flags is set.
- R9: `rxd_level` is `rxd_in` delayed by a two-stage synchroniser, so it follows the line two clock cycles later.
- R10: Error flags stay set until `clr_err` is pulsed, however many frames arrive in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle enable at sixteen times the bit rate |
| rxd_in | input | 1 | Serial line, idles high |
| cfg_len7 | input | 1 | 1: seven data bits, 0: eight |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_mp_en | input | 1 | Multiprocessor bit present |
| clr_full | input | 1 | Host has read the byte, clears rx_full |
| clr_err | input | 1 | Clears all error flags |
| rx_data | output | 8 | Held received byte |
| rx_mpb | output | 1 | Held multiprocessor bit |
| rx_full | output | 1 | Holding register contains an unread byte |
| err_parity | output | 1 | Sticky parity fault |
| err_frame | output | 1 | Sticky framing fault |
| err_overrun | output | 1 | Sticky overrun fault |
| irq_rx_full | output | 1 | Byte-ready request |
| irq_rx_err | output | 1 | Receive-error request |
| rxd_level | output | 1 | Synchronised live line level |

## Verification
A wrong sample point or bit counter shows up as a corrupt `rx_data`, or as a spurious parity or framing flag, at the end of the frame in which it happens. A misplaced parity or multiprocessor state shifts every following bit, so the byte and flags of that same frame go wrong. A lost start-bit re-arm condition shows within one frame time of a break as an unexpected `rx_full`. Overrun and clear priority errors appear on the flags in the cycle after the completing frame or the strobe.

// File: rtl/sci_async_rx.sv
module sci_async_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd_in,
  input  logic       cfg_len7,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_mp_en,
  input  logic       clr_full,
  input  logic       clr_err,
  output logic [7:0] rx_data,
  output logic       rx_mpb,
  output logic       rx_full,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       irq_rx_full,
  output logic       irq_rx_err,
  output logic       rxd_level
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_MPB, S_STOP} st_t;

  st_t        st;
  logic       sync1, sync2, armed;
  logic [3:0] tcnt;
  logic [2:0] bcnt;
  logic [7:0] shreg;
  logic       par_bit, mp_bit;

  wire       mid        = tick16 && (tcnt == 4'd15);
  wire [2:0] last_bit   = cfg_len7 ? 3'd6 : 3'd7;
  wire [7:0] data_out   = cfg_len7 ? {1'b0, shreg[7:1]} : shreg;
  wire       frame_done = mid && (st == S_STOP);
  wire       par_bad    = cfg_par_en && ((^data_out ^ par_bit) != cfg_par_odd);

  assign rxd_level   = sync2;
  assign irq_rx_full = rx_full;
  assign irq_rx_err  = err_parity | err_frame | err_overrun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1   <= 1'b1;
      sync2   <= 1'b1;
      st      <= S_IDLE;
      armed   <= 1'b0;
      tcnt    <= '0;
      bcnt    <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      mp_bit  <= 1'b0;
    end else begin
      sync1 <= rxd_in;
      sync2 <= sync1;
      if (tick16) begin
        case (st)
          S_IDLE: begin
            if (sync2) armed <= 1'b1;
            else if (armed) begin
              st   <= S_START;
              tcnt <= '0;
            end
          end
          S_START: begin
            if (tcnt == 4'd7) begin
              tcnt <= '0;
              bcnt <= '0;
              st   <= sync2 ? S_IDLE : S_DATA;
            end else begin
              tcnt <= tcnt + 4'd1;
            end
          end
          default: begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == 4'd15) begin
              case (st)
                S_DATA: begin
                  shreg <= {sync2, shreg[7:1]};
                  bcnt  <= bcnt + 3'd1;
                  if (bcnt == last_bit)
                    st <= cfg_par_en ? S_PAR : (cfg_mp_en ? S_MPB : S_STOP);
                end
                S_PAR: begin
                  par_bit <= sync2;
                  st      <= cfg_mp_en ? S_MPB : S_STOP;
                end
                S_MPB: begin
                  mp_bit <= sync2;
                  st     <= S_STOP;
                end
                default: begin
                  st    <= S_IDLE;
                  armed <= sync2;
                end
              endcase
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_mpb      <= 1'b0;
      rx_full     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (clr_full) rx_full <= 1'b0;
      if (clr_err) begin
        err_parity  <= 1'b0;
        err_frame   <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (frame_done) begin
        if (rx_full) begin
          err_overrun <= 1'b1;
        end else begin
          rx_data <= data_out;
          rx_mpb  <= cfg_mp_en & mp_bit;
          rx_full <= 1'b1;
          if (par_bad) err_parity <= 1'b1;
          if (!sync2)  err_frame  <= 1'b1;
        end
      end
    end
  end

  a_r6_held_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> $stable(rx_data) && $stable(rx_mpb));
  a_r6_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_full));
  a_r5_frame_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> $past(frame_done));
  a_r3_parity_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity) |-> $past(cfg_par_en));
  a_r10_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame && !clr_err |=> err_frame);
  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun && !clr_err |=> err_overrun);
  a_r7_clear_full: assert property (@(posedge clk) disable iff (!rst_n)
    clr_full && !frame_done |=> !rx_full);
  a_r1_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START) && $past(st) != S_START |-> $past(st) == S_IDLE && !$past(sync2));

endmodule

// File: tb/sci_async_rx_tb.sv
module sci_async_rx_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rxd_in = 1'b1;
  logic cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_mp_en = 1'b0;
  logic clr_full = 1'b0, clr_err = 1'b0;
  logic [7:0] rx_data;
  logic rx_mpb, rx_full, err_parity, err_frame, err_overrun, irq_rx_full, irq_rx_err, rxd_level;

  int checks = 0, errors = 0;
  logic done = 1'b0;
  logic [7:0] m_data = '0;
  logic m_mpb = 1'b0, m_full = 1'b0, m_pe = 1'b0, m_fe = 1'b0, m_oe = 1'b0;
  logic idle_level = 1'b1;
  int unsigned seed = 32'd2718;
  logic [1:0] tdiv = '0;

  sci_async_rx u_dut (.*);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  function automatic logic [7:0] exp_data(input logic [7:0] d, input logic len7);
    return len7 ? {1'b0, d[6:0]} : d;
  endfunction

  function automatic logic par_bit_for(input logic [7:0] d, input logic len7, input logic odd);
    return (^exp_data(d, len7)) ^ odd;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R6 rx_data"}, rx_data, m_data);
    chk({tag, " R4 rx_mpb"}, rx_mpb, m_mpb);
    chk({tag, " R6 rx_full"}, rx_full, m_full);
    chk({tag, " R3 err_parity"}, err_parity, m_pe);
    chk({tag, " R5 err_frame"}, err_frame, m_fe);
    chk({tag, " R6 err_overrun"}, err_overrun, m_oe);
    chk({tag, " R8 irq_rx_full"}, irq_rx_full, m_full);
    chk({tag, " R8 irq_rx_err"}, irq_rx_err, m_pe | m_fe | m_oe);
  endtask

  task automatic bit_cell(input logic v);
    rxd_in = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic len7, input logic pe, input logic po,
                      input logic mp, input logic mpb, input logic bad_par,
                      input logic stop_v, input logic two_stop);
    cfg_len7 = len7; cfg_par_en = pe; cfg_par_odd = po; cfg_mp_en = mp;
    bit_cell(1'b0);
    for (int i = 0; i < (len7 ? 7 : 8); i++) bit_cell(d[i]);
    if (pe) bit_cell(par_bit_for(d, len7, po) ^ bad_par);
    if (mp) bit_cell(mpb);
    bit_cell(stop_v);
    if (two_stop) bit_cell(1'b1);
    if (m_full) m_oe = 1'b1;
    else begin
      m_data = exp_data(d, len7);
      m_mpb  = mp & mpb;
      m_full = 1'b1;
      if (pe && bad_par) m_pe = 1'b1;
      if (!stop_v) m_fe = 1'b1;
    end
    bit_cell(idle_level);
  endtask

  task automatic pulse_full();
    @(negedge clk) clr_full = 1'b1;
    @(negedge clk) clr_full = 1'b0;
    m_full = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_err();
    @(negedge clk) clr_err = 1'b1;
    @(negedge clk) clr_err = 1'b0;
    m_pe = 1'b0; m_fe = 1'b0; m_oe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(seed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("reset");
    chk("R9 idle level", rxd_level, 1'b1);

    rxd_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 level low", rxd_level, 1'b0);
    rxd_in = 1'b1;
    @(negedge clk);
    chk("R9 not yet high", rxd_level, 1'b0);
    repeat (2) @(negedge clk);
    chk("R9 level high", rxd_level, 1'b1);
    repeat (200) @(negedge clk);

    rxd_in = 1'b0;
    repeat (12) @(negedge clk);
    rxd_in = 1'b1;
    repeat (400) @(negedge clk);
    check_all("R1 glitch ignored");
    send(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_all("R1 R2 frame after glitch");
    pulse_full();

    send(8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R2 seven-bit top bit zero", rx_data, 8'h7F);
    pulse_full();

    send(8'h3C, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    check_all("R3 R4 odd parity mp two stop");
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_all("R6 overrun keeps byte");
    pulse_full();
    pulse_err();
    check_all("R7 clears");

    send(8'h96, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check_all("R3 even parity fault");
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_all("R10 parity flag sticky across overrun");
    pulse_full();
    pulse_err();

    idle_level = 1'b0;
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check_all("R5 break frame");
    chk("R5 break line low", rxd_level, 1'b0);
    pulse_full();
    repeat (64 * 30) @(negedge clk);
    check_all("R5 no restart while low");
    idle_level = 1'b1;
    bit_cell(1'b1);
    pulse_err();
    send(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_all("R5 recovery after break");
    pulse_full();

    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      logic l7, pe, po, mp, mb, bp, sv, ts;
      d  = 8'($urandom);
      l7 = 1'($urandom);
      pe = 1'($urandom);
      po = 1'($urandom);
      mp = 1'($urandom);
      mb = 1'($urandom);
      bp = pe && ($urandom % 6 == 0);
      sv = ($urandom % 8 != 0);
      ts = 1'($urandom);
      send(d, l7, pe, po, mp, mb, bp, sv, ts);
      check_all("random R2 R3 R4 R6");
      if ($urandom % 2 == 0) pulse_full();
      if ($urandom % 3 == 0) pulse_err();
      check_all("random R7 R10");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule